// File: doc/BRIEF.md
# Pending Load Register Write Tracker

This block follows the results of long-latency loads as they come back from memory. A single load can split into several memory requests, and each request returns its own reply. The tracker therefore keeps a small associative table. Each live entry holds a warp number, a destination register number and a count of replies still outstanding for that pair.

The memory side reports two kinds of event. When a request is sent for a load, the counter of every distinct destination register of that load goes up by one. When a reply is accepted, those counters go down by one. The counter that drops from one to zero frees its entry and queues exactly one release event for the scoreboard. Release events leave one per cycle, oldest first.

A combinational query port tells the dispatch stage whether a load still has any destination register with a live entry. The dispatch stage uses the answer to decide whether it can release the load's registers at once or must leave that to the release stream.

Top module: `pend_wr_table`

## Requirements
- R1: An instruction carries SLOTS register fields; slot s sits at bits [s*REG_W +: REG_W] of the register vector. A field equal to 0 is unused and ignored. A register number that repeats within one instruction counts once.
- R2: An accepted increment (inc_valid and inc_ready) adds one to the counter of each distinct valid register of inc_warp. A register with no live entry gets a new entry with count 1.
- R3: An accepted reply (dec_valid and dec_ready) subtracts one from the counter of each distinct valid register of dec_warp. A reply register with no live entry is ignored, and cnt_err is high for one cycle after that clock edge.
- R4: When a counter goes from 1 to 0, its entry is freed and exactly one release (warp, register) is queued. Releases within one reply are queued in slot order. The head of the queue is shown on rel_valid/rel_warp/rel_reg for one cycle and then dropped. A release reaches an empty queue in the cycle after the reply's clock edge.
- R5: If an accepted increment and an accepted reply name the same warp and register in one cycle, the counter keeps its value and no release is produced.
- R6: qry_pending is combinational. It is 1 exactly when some distinct valid register of qry_regs has a live entry for qry_warp.
- R7: inc_ready is 1 exactly when at least SLOTS table entries are free. An increment offered while inc_ready is 0 has no effect.
- R8: dec_ready is 1 exactly when at least SLOTS release-queue places are free. A reply offered while dec_ready is 0 has no effect.
- R9: An increment that does not coincide with a reply on the same entry, and that hits a counter already at 2^CNT_W-1, leaves the counter unchanged. cnt_err is high for one cycle after that clock edge.
- R10: After reset the table and the release queue are empty: rel_valid and cnt_err are 0, and inc_ready and dec_ready are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_valid | input | 1 | One memory request for a load is being sent |
| inc_warp | input | WARP_W | Warp of that load |
| inc_regs | input | SLOTS*REG_W | Destination register fields of that load |
| inc_ready | output | 1 | Table has room for a full increment |
| dec_valid | input | 1 | One load reply is being accepted |
| dec_warp | input | WARP_W | Warp of the reply |
| dec_regs | input | SLOTS*REG_W | Destination register fields of the reply |
| dec_ready | output | 1 | Release queue has room for a full reply |
| qry_warp | input | WARP_W | Warp of the instruction being queried |
| qry_regs | input | SLOTS*REG_W | Register fields of the instruction being queried |
| qry_pending | output | 1 | Some queried register still has outstanding replies |
| rel_valid | output | 1 | Release event valid this cycle |
| rel_warp | output | WARP_W | Warp of the released register |
| rel_reg | output | REG_W | Released register number |
| cnt_err | output | 1 | Reply to an absent entry, or counter at its ceiling, in the previous cycle |

## Verification
qry_pending depends only on the table state and the current query, so the bench changes the query inputs and reads the answer a fraction of a cycle later, before the next edge. An increment or reply presented before edge k changes inc_ready, dec_ready and cnt_err after edge k. A release reaches rel_* after edge k when the queue was empty, and otherwise waits one cycle for each queued event ahead of it. The behavioural reference model applies each event at the same posedge as the design and compares every output at the following negedge, so each expected value falls in exactly the cycle these latencies give. The directed cases use hand-computed values in those same cycles.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

  typedef enum logic [1:0] {
    D_HOLD = 2'd0,
    D_UP   = 2'd1,
    D_DOWN = 2'd2
  } delta_e;

  // net effect of one increment and one decrement request on an entry
  function automatic delta_e entry_delta(input logic up, input logic down);
    if (up && !down)      return D_UP;
    else if (down && !up) return D_DOWN;
    else                  return D_HOLD;
  endfunction

endpackage

// File: rtl/pwt_slot_filter.sv
module pwt_slot_filter #(
  parameter int SLOTS = 4,
  parameter int REG_W = 6
) (
  input  logic [SLOTS*REG_W-1:0] regs_i,
  output logic [SLOTS-1:0]       use_o
);

  function automatic logic [REG_W-1:0] field(input logic [SLOTS*REG_W-1:0] v, input int s);
    return v[s*REG_W +: REG_W];
  endfunction

  // slot is used when non-zero and first of its value (R1)
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      use_o[s] = |field(regs_i, s);
      for (int p = 0; p < s; p++)
        if (field(regs_i, p) == field(regs_i, s)) use_o[s] = 1'b0;
    end
  end

endmodule

// File: rtl/pwt_entry_array.sv
module pwt_entry_array
  import pwt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int SLOTS   = 4,
  parameter int WARP_W  = 3,
  parameter int REG_W   = 6,
  parameter int CNT_W   = 4,
  localparam int LC_W   = $clog2(ENTRIES+1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inc_fire,
  input  logic [WARP_W-1:0]      inc_warp,
  input  logic [SLOTS*REG_W-1:0] inc_regs,
  input  logic [SLOTS-1:0]       inc_use,
  input  logic                   dec_fire,
  input  logic [WARP_W-1:0]      dec_warp,
  input  logic [SLOTS*REG_W-1:0] dec_regs,
  input  logic [SLOTS-1:0]       dec_use,
  input  logic [WARP_W-1:0]      qry_warp,
  input  logic [SLOTS*REG_W-1:0] qry_regs,
  input  logic [SLOTS-1:0]       qry_use,
  output logic                   qry_hit,
  output logic [SLOTS-1:0]       zero_ev,
  output logic                   dec_miss_any,
  output logic                   inc_sat_any,
  output logic [LC_W-1:0]        live_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ENTRIES-1:0] vld_q;
  logic [WARP_W-1:0]  warp_q [ENTRIES];
  logic [REG_W-1:0]   reg_q  [ENTRIES];
  logic [CNT_W-1:0]   cnt_q  [ENTRIES];

  logic [ENTRIES-1:0] inc_any, dec_any, alloc_e, taken;
  logic [REG_W-1:0]   alloc_reg [ENTRIES];
  logic [SLOTS-1:0]   inc_found, dec_found, dec_one, dec_clash;
  logic               picked;

  function automatic logic [REG_W-1:0] field(input logic [SLOTS*REG_W-1:0] v, input int s);
    return v[s*REG_W +: REG_W];
  endfunction

  function automatic logic [LC_W-1:0] count_live(input logic [ENTRIES-1:0] v);
    logic [LC_W-1:0] n;
    n = '0;
    for (int i = 0; i < ENTRIES; i++) n = n + LC_W'(v[i]);
    return n;
  endfunction

  function automatic logic entry_match(input logic vld, input logic [WARP_W-1:0] ew,
                                       input logic [REG_W-1:0] er, input logic [WARP_W-1:0] w,
                                       input logic [REG_W-1:0] r);
    return vld && (ew == w) && (er == r);
  endfunction

  always_comb begin
    inc_any   = '0;
    dec_any   = '0;
    alloc_e   = '0;
    inc_found = '0;
    dec_found = '0;
    dec_one   = '0;
    dec_clash = '0;
    qry_hit   = 1'b0;
    picked    = 1'b0;
    taken     = vld_q;
    for (int e = 0; e < ENTRIES; e++) alloc_reg[e] = '0;

    // increment side: match live entries
    for (int s = 0; s < SLOTS; s++)
      for (int e = 0; e < ENTRIES; e++)
        if (inc_fire && inc_use[s] &&
            entry_match(vld_q[e], warp_q[e], reg_q[e], inc_warp, field(inc_regs, s))) begin
          inc_any[e]   = 1'b1;
          inc_found[s] = 1'b1;
        end

    // reply side: match live entries, note the ones reaching zero
    for (int s = 0; s < SLOTS; s++)
      for (int e = 0; e < ENTRIES; e++)
        if (dec_fire && dec_use[s] &&
            entry_match(vld_q[e], warp_q[e], reg_q[e], dec_warp, field(dec_regs, s))) begin
          dec_any[e]   = 1'b1;
          dec_found[s] = 1'b1;
          dec_one[s]   = (cnt_q[e] == CNT_ONE);
          dec_clash[s] = inc_any[e];
        end

    // query side
    for (int s = 0; s < SLOTS; s++)
      for (int e = 0; e < ENTRIES; e++)
        if (qry_use[s] &&
            entry_match(vld_q[e], warp_q[e], reg_q[e], qry_warp, field(qry_regs, s)))
          qry_hit = 1'b1;

    // allocate lowest free entries for increments that found nothing
    for (int s = 0; s < SLOTS; s++) begin
      picked = 1'b0;
      if (inc_fire && inc_use[s] && !inc_found[s])
        for (int e = 0; e < ENTRIES; e++)
          if (!picked && !taken[e]) begin
            alloc_e[e]   = 1'b1;
            alloc_reg[e] = field(inc_regs, s);
            taken[e]     = 1'b1;
            picked       = 1'b1;
          end
    end
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++)
      zero_ev[s] = dec_found[s] && dec_one[s] && !dec_clash[s];
    dec_miss_any = dec_fire && |(dec_use & ~dec_found);
    inc_sat_any  = 1'b0;
    for (int e = 0; e < ENTRIES; e++)
      if (inc_any[e] && !dec_any[e] && cnt_q[e] == CNT_MAX) inc_sat_any = 1'b1;
  end

  assign live_count = count_live(vld_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        warp_q[e] <= '0;
        reg_q[e]  <= '0;
        cnt_q[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (alloc_e[e]) begin
          vld_q[e]  <= 1'b1;
          warp_q[e] <= inc_warp;
          reg_q[e]  <= alloc_reg[e];
          cnt_q[e]  <= CNT_ONE;
        end else if (vld_q[e]) begin
          case (entry_delta(inc_any[e], dec_any[e]))
            D_UP: begin
              if (cnt_q[e] != CNT_MAX) cnt_q[e] <= cnt_q[e] + 1'b1;
            end
            D_DOWN: begin
              if (cnt_q[e] == CNT_ONE) begin
                vld_q[e] <= 1'b0;
                cnt_q[e] <= '0;
              end else begin
                cnt_q[e] <= cnt_q[e] - 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/pwt_release_fifo.sv
module pwt_release_fifo #(
  parameter int DEPTH = 8,
  parameter int SLOTS = 4,
  parameter int DW    = 9,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int QC_W  = $clog2(DEPTH+1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOTS-1:0]          push,
  input  logic [SLOTS-1:0][DW-1:0]  push_data,
  output logic                      head_valid,
  output logic [DW-1:0]             head_data,
  output logic                      room_ok,
  output logic [QC_W-1:0]           count
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [PTR_W-1:0] pos [SLOTS];
  logic [QC_W-1:0]  npush;
  logic             pop;

  // pack this cycle's pushes densely in slot order
  always_comb begin
    npush = '0;
    for (int s = 0; s < SLOTS; s++) begin
      pos[s] = wr_ptr + PTR_W'(npush);
      if (push[s]) npush = npush + 1'b1;
    end
  end

  assign pop        = (count != '0);
  assign head_valid = pop;
  assign head_data  = mem[rd_ptr];
  assign room_ok    = (QC_W'(DEPTH) - count) >= QC_W'(SLOTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      wr_ptr <= wr_ptr + PTR_W'(npush);
      count  <= count - QC_W'(pop) + npush;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++)
      if (push[s]) mem[pos[s]] <= push_data[s];
  end

endmodule

// File: rtl/pend_wr_table.sv
module pend_wr_table #(
  parameter int WARP_W     = 3,
  parameter int REG_W      = 6,
  parameter int SLOTS      = 4,
  parameter int ENTRIES    = 16,
  parameter int CNT_W      = 4,
  parameter int RELQ_DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inc_valid,
  input  logic [WARP_W-1:0]      inc_warp,
  input  logic [SLOTS*REG_W-1:0] inc_regs,
  output logic                   inc_ready,
  input  logic                   dec_valid,
  input  logic [WARP_W-1:0]      dec_warp,
  input  logic [SLOTS*REG_W-1:0] dec_regs,
  output logic                   dec_ready,
  input  logic [WARP_W-1:0]      qry_warp,
  input  logic [SLOTS*REG_W-1:0] qry_regs,
  output logic                   qry_pending,
  output logic                   rel_valid,
  output logic [WARP_W-1:0]      rel_warp,
  output logic [REG_W-1:0]       rel_reg,
  output logic                   cnt_err
);

  localparam int LC_W = $clog2(ENTRIES+1);
  localparam int QC_W = $clog2(RELQ_DEPTH+1);
  localparam int RW   = WARP_W + REG_W;

  logic [SLOTS-1:0]         inc_use, dec_use, qry_use;
  logic                     inc_fire, dec_fire;
  logic [SLOTS-1:0]         zero_ev;
  logic                     dec_miss_any, inc_sat_any;
  logic [LC_W-1:0]          live_count;
  logic [QC_W-1:0]          relq_count;
  logic [SLOTS-1:0][RW-1:0] rel_words;
  logic [RW-1:0]            head_word;
  logic                     cnt_err_q;

  function automatic logic has_room(input logic [LC_W-1:0] live);
    return (LC_W'(ENTRIES) - live) >= LC_W'(SLOTS);
  endfunction

  pwt_slot_filter #(.SLOTS(SLOTS), .REG_W(REG_W)) u_inc_filt (.regs_i(inc_regs), .use_o(inc_use));
  pwt_slot_filter #(.SLOTS(SLOTS), .REG_W(REG_W)) u_dec_filt (.regs_i(dec_regs), .use_o(dec_use));
  pwt_slot_filter #(.SLOTS(SLOTS), .REG_W(REG_W)) u_qry_filt (.regs_i(qry_regs), .use_o(qry_use));

  assign inc_ready = has_room(live_count);
  assign inc_fire  = inc_valid && inc_ready;
  assign dec_fire  = dec_valid && dec_ready;

  pwt_entry_array #(
    .ENTRIES(ENTRIES), .SLOTS(SLOTS), .WARP_W(WARP_W), .REG_W(REG_W), .CNT_W(CNT_W)
  ) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_fire    (inc_fire),
    .inc_warp    (inc_warp),
    .inc_regs    (inc_regs),
    .inc_use     (inc_use),
    .dec_fire    (dec_fire),
    .dec_warp    (dec_warp),
    .dec_regs    (dec_regs),
    .dec_use     (dec_use),
    .qry_warp    (qry_warp),
    .qry_regs    (qry_regs),
    .qry_use     (qry_use),
    .qry_hit     (qry_pending),
    .zero_ev     (zero_ev),
    .dec_miss_any(dec_miss_any),
    .inc_sat_any (inc_sat_any),
    .live_count  (live_count)
  );

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_words
      assign rel_words[s] = {dec_warp, dec_regs[s*REG_W +: REG_W]};
    end
  endgenerate

  pwt_release_fifo #(.DEPTH(RELQ_DEPTH), .SLOTS(SLOTS), .DW(RW)) u_relq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (zero_ev),
    .push_data (rel_words),
    .head_valid(rel_valid),
    .head_data (head_word),
    .room_ok   (dec_ready),
    .count     (relq_count)
  );

  assign rel_warp = head_word[RW-1:REG_W];
  assign rel_reg  = head_word[REG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_err_q <= 1'b0;
    else        cnt_err_q <= dec_miss_any || inc_sat_any;
  end
  assign cnt_err = cnt_err_q;

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int ENTRIES    = 16,
  parameter int SLOTS      = 4,
  parameter int REG_W      = 6,
  parameter int RELQ_DEPTH = 8,
  localparam int LC_W = $clog2(ENTRIES+1),
  localparam int QC_W = $clog2(RELQ_DEPTH+1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inc_valid,
  input logic             inc_ready,
  input logic             qry_pending,
  input logic             rel_valid,
  input logic [REG_W-1:0] rel_reg,
  input logic             cnt_err,
  input logic [LC_W-1:0]  live_count,
  input logic [QC_W-1:0]  relq_count,
  input logic [SLOTS-1:0] zero_ev,
  input logic             dec_miss_any
);

  // R1: a released register is never the unused field value
  p_rel_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> rel_reg != '0);

  // R4: a counter reaching zero shows a release in the next cycle
  p_zero_then_rel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|zero_ev) |=> rel_valid);

  // R4: only a live entry can reach zero
  p_zero_needs_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|zero_ev) |-> live_count != '0);

  // R3: a reply to an absent entry raises the error flag next cycle
  p_miss_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_miss_any |=> cnt_err);

  // R6: an empty table reports nothing pending
  p_qry_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live_count == '0 |-> !qry_pending);

  // R7: a stalled increment allocates no entry
  p_stall_no_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_valid && !inc_ready) |=> live_count <= $past(live_count));

  // R8: the release queue never holds more than its depth
  p_relq_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    relq_count <= QC_W'(RELQ_DEPTH));

endmodule

bind pend_wr_table pwt_checker #(
  .ENTRIES(ENTRIES), .SLOTS(SLOTS), .REG_W(REG_W), .RELQ_DEPTH(RELQ_DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inc_valid   (inc_valid),
  .inc_ready   (inc_ready),
  .qry_pending (qry_pending),
  .rel_valid   (rel_valid),
  .rel_reg     (rel_reg),
  .cnt_err     (cnt_err),
  .live_count  (live_count),
  .relq_count  (relq_count),
  .zero_ev     (zero_ev),
  .dec_miss_any(dec_miss_any)
);

// File: tb/test_pend_wr_table.sv
`timescale 1ns/1ps
module test_pend_wr_table;

  localparam int WARP_W = 3, REG_W = 6, SLOTS = 4, ENTRIES = 16, CNT_W = 4, RELQ = 8;
  localparam int K = 1 << REG_W;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inc_valid = 1'b0, dec_valid = 1'b0;
  logic [WARP_W-1:0] inc_warp = '0, dec_warp = '0, qry_warp = '0;
  logic [SLOTS*REG_W-1:0] inc_regs = '0, dec_regs = '0, qry_regs = '0;
  logic inc_ready, dec_ready, qry_pending, rel_valid, cnt_err;
  logic [WARP_W-1:0] rel_warp;
  logic [REG_W-1:0] rel_reg;

  always #2 clk = ~clk;

  pend_wr_table i_pend_wr_table (
    .clk(clk), .rst_n(rst_n),
    .inc_valid(inc_valid), .inc_warp(inc_warp), .inc_regs(inc_regs), .inc_ready(inc_ready),
    .dec_valid(dec_valid), .dec_warp(dec_warp), .dec_regs(dec_regs), .dec_ready(dec_ready),
    .qry_warp(qry_warp), .qry_regs(qry_regs), .qry_pending(qry_pending),
    .rel_valid(rel_valid), .rel_warp(rel_warp), .rel_reg(rel_reg), .cnt_err(cnt_err)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  int mcnt[int];
  int relq[$];
  bit m_err = 1'b0;

  function automatic void slot_keys(input logic [SLOTS*REG_W-1:0] regs, input int w, output int keys[$]);
    keys = {};
    for (int s = 0; s < SLOTS; s++) begin
      int r = int'(regs[s*REG_W +: REG_W]);
      bit dup = 1'b0;
      foreach (keys[i]) if (keys[i] == w*K + r) dup = 1'b1;
      if (r != 0 && !dup) keys.push_back(w*K + r);
    end
  endfunction

  function automatic bit has(input int q[$], input int k);
    foreach (q[i]) if (q[i] == k) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [SLOTS*REG_W-1:0] pk(input int a, input int b, input int c, input int d);
    return {REG_W'(d), REG_W'(c), REG_W'(b), REG_W'(a)};
  endfunction

  task automatic model_step();
    int pre[int];
    int ik[$], dk[$];
    bit inc_ok, dec_ok, err;
    pre = mcnt;
    inc_ok = inc_valid && (ENTRIES - pre.num() >= SLOTS);
    dec_ok = dec_valid && (RELQ - relq.size() >= SLOTS);
    if (relq.size() > 0) void'(relq.pop_front());
    ik = {}; dk = {};
    if (inc_ok) slot_keys(inc_regs, int'(inc_warp), ik);
    if (dec_ok) slot_keys(dec_regs, int'(dec_warp), dk);
    err = 1'b0;
    foreach (dk[i]) if (!pre.exists(dk[i])) err = 1'b1;
    foreach (ik[i]) begin
      if (pre.exists(ik[i])) begin
        if (!has(dk, ik[i])) begin
          if (pre[ik[i]] == CMAX) err = 1'b1;
          else mcnt[ik[i]] = pre[ik[i]] + 1;
        end
      end else mcnt[ik[i]] = 1;
    end
    foreach (dk[i]) begin
      if (pre.exists(dk[i]) && !has(ik, dk[i])) begin
        if (pre[dk[i]] == 1) begin
          mcnt.delete(dk[i]);
          relq.push_back(dk[i]);
        end else mcnt[dk[i]] = pre[dk[i]] - 1;
      end
    end
    m_err = err;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt.delete(); relq = {}; m_err = 1'b0;
    end else model_step();
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int qk[$];
    bit pend;
    chk("R7 inc_ready", int'(inc_ready), int'((ENTRIES - mcnt.num()) >= SLOTS));
    chk("R8 dec_ready", int'(dec_ready), int'((RELQ - relq.size()) >= SLOTS));
    slot_keys(qry_regs, int'(qry_warp), qk);
    pend = 1'b0;
    foreach (qk[i]) if (mcnt.exists(qk[i])) pend = 1'b1;
    chk("R6 qry_pending", int'(qry_pending), int'(pend));
    chk("R4 rel_valid", int'(rel_valid), int'(relq.size() > 0));
    if (relq.size() > 0) begin
      chk("R4 rel_warp", int'(rel_warp), relq[0] / K);
      chk("R4 rel_reg", int'(rel_reg), relq[0] % K);
    end
    chk("R3 cnt_err", int'(cnt_err), int'(m_err));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    inc_valid = 1'b0; dec_valid = 1'b0;
  endtask

  task automatic set_inc(input int w, input logic [SLOTS*REG_W-1:0] r);
    inc_valid = 1'b1; inc_warp = WARP_W'(w); inc_regs = r;
  endtask

  task automatic set_dec(input int w, input logic [SLOTS*REG_W-1:0] r);
    dec_valid = 1'b1; dec_warp = WARP_W'(w); dec_regs = r;
  endtask

  task automatic ask(input int w, input logic [SLOTS*REG_W-1:0] r);
    qry_warp = WARP_W'(w); qry_regs = r;
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk("R10 rel_valid", int'(rel_valid), 0);
    chk("R10 cnt_err", int'(cnt_err), 0);
    chk("R10 inc_ready", int'(inc_ready), 1);
    chk("R10 dec_ready", int'(dec_ready), 1);
    ask(1, pk(5, 0, 0, 0));
    chk("R10 qry_pending", int'(qry_pending), 0);

    // R1: zero slots ignored, repeated register counts once
    set_inc(1, pk(0, 5, 5, 0)); cyc(); idle();
    ask(1, pk(5, 0, 0, 0));
    chk("R1 qry after inc", int'(qry_pending), 1);
    set_dec(1, pk(5, 0, 0, 0)); cyc(); idle();
    chk("R1 rel_valid", int'(rel_valid), 1);
    chk("R1 rel_warp", int'(rel_warp), 1);
    chk("R1 rel_reg", int'(rel_reg), 5);
    cyc();
    chk("R4 single release", int'(rel_valid), 0);

    // R2: two requests need two replies
    set_inc(2, pk(7, 0, 0, 0)); cyc(); cyc(); idle();
    set_dec(2, pk(7, 0, 0, 0)); cyc(); idle();
    chk("R2 no release at count 1", int'(rel_valid), 0);
    ask(2, pk(0, 7, 0, 0));
    chk("R2 still pending", int'(qry_pending), 1);
    set_dec(2, pk(7, 0, 0, 0)); cyc(); idle();
    chk("R2 release reg", int'(rel_reg), 7);
    chk("R2 release valid", int'(rel_valid), 1);

    // R5: same entry up and down in one cycle
    set_inc(3, pk(9, 0, 0, 0)); cyc();
    set_dec(3, pk(9, 0, 0, 0)); cyc(); idle();
    chk("R5 no release", int'(rel_valid), 0);
    ask(3, pk(9, 0, 0, 0));
    chk("R5 entry kept", int'(qry_pending), 1);
    set_dec(3, pk(9, 0, 0, 0)); cyc(); idle();
    chk("R5 later release", int'(rel_valid), 1);
    cyc();

    // R3: reply without entry
    set_dec(4, pk(11, 0, 0, 0)); cyc(); idle();
    chk("R3 err flag", int'(cnt_err), 1);
    chk("R3 no release", int'(rel_valid), 0);
    cyc();
    chk("R3 err one cycle", int'(cnt_err), 0);

    // R9: counter ceiling
    set_inc(5, pk(12, 0, 0, 0));
    for (int i = 0; i < CMAX; i++) cyc();
    chk("R9 no err below ceiling", int'(cnt_err), 0);
    cyc(); idle();
    chk("R9 err at ceiling", int'(cnt_err), 1);
    set_dec(5, pk(12, 0, 0, 0));
    for (int i = 0; i < CMAX - 1; i++) cyc();
    chk("R9 held at max", int'(rel_valid), 0);
    cyc(); idle();
    chk("R9 release after max replies", int'(rel_valid), 1);
    cyc();

    // R7: fill the table
    set_inc(0, pk(1, 2, 3, 4)); cyc();
    set_inc(0, pk(5, 6, 7, 8)); cyc();
    set_inc(0, pk(9, 10, 11, 12)); cyc();
    chk("R7 room for last group", int'(inc_ready), 1);
    set_inc(0, pk(13, 14, 15, 16)); cyc();
    chk("R7 full", int'(inc_ready), 0);
    set_inc(0, pk(20, 0, 0, 0)); cyc(); idle();
    ask(0, pk(20, 0, 0, 0));
    chk("R7 stalled inc ignored", int'(qry_pending), 0);

    // R8: release queue pressure
    set_dec(0, pk(1, 2, 3, 4)); cyc();
    chk("R8 ready at 4 queued", int'(dec_ready), 1);
    set_dec(0, pk(5, 6, 7, 8)); cyc();
    chk("R8 not ready at 7 queued", int'(dec_ready), 0);
    set_dec(0, pk(9, 10, 11, 12)); cyc(); idle();
    ask(0, pk(9, 0, 0, 0));
    chk("R8 stalled reply ignored", int'(qry_pending), 1);
    repeat (8) cyc();
    set_dec(0, pk(9, 10, 11, 12)); cyc(); idle();
    repeat (4) cyc();
    set_dec(0, pk(16, 15, 14, 13)); cyc(); idle();
    repeat (8) cyc();
    chk("R7 table empty again", int'(inc_ready), 1);

    // mixed traffic against the reference model
    for (int i = 0; i < 4000; i++) begin
      inc_valid = ($urandom_range(0, 2) != 0);
      inc_warp  = WARP_W'($urandom_range(0, 3));
      inc_regs  = pk($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
      dec_valid = ($urandom_range(0, 2) != 0);
      dec_warp  = WARP_W'($urandom_range(0, 3));
      dec_regs  = pk($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
      qry_warp  = WARP_W'($urandom_range(0, 3));
      qry_regs  = pk($urandom_range(0, 7), $urandom_range(0, 7), 0, 0);
      cyc();
    end
    idle();
    repeat (20) cyc();
    finish_run();
  end

endmodule